// File: doc/BRIEF.md
# Bus Error Exception Controller

This block sits beside the bus interface of a pipelined processor core and decides when a faulted bus cycle turns into a bus-error exception. Three sources can flag a failed cycle: an external error pin, an internal peripheral module, and the on-chip watchdog that fires when a cycle gets no answer. Each access the core issues is tagged as an instruction prefetch, a data read, an ordinary data write or a released (posted) operand write. The tag decides how quickly the fault becomes visible to the core.

Data reads and ordinary writes raise the request at once. A faulted prefetch is parked against its prefetch slot and raised only if the core later consumes that word. A flush throws the parked fault away. A faulted released write waits for the next instruction boundary or operand-access attempt. Every request carries a captured fault record for stacking: access size, direction, access class, function code and fault address. The fixed bus-error vector number comes with it. If a bus error arrives while the core is in a critical exception phase, the block halts and stays halted until reset.

Top module: `berr_exc_ctrl`

## Requirements
- R1: A bus cycle counts as faulted when `acc_valid` is high and at least one of `err_ext`, `err_mod`, `err_wdog` is high in the same cycle; with all three low no request follows.
- R2: A faulted data read (`acc_kind`=1) or ordinary data write (`acc_kind`=2) outside a critical phase, with the delivery stage idle, makes `exc_req` high in the cycle after the fault, with `rec_addr` equal to the faulted address.
- R3: The record carries `rec_kind` = the access code (0 prefetch, 1 data read, 2 data write, 3 released write), `rec_read` = 1 for codes 0 and 1 and 0 otherwise, and `rec_size`/`rec_fc` copied from the access; `vector_num` always reads 2.
- R4: A faulted prefetch (`acc_kind`=0) is stored against `acc_slot` and raises nothing until `pf_use` names that slot; the request then follows one cycle after the use, and a second use of the same slot raises nothing.
- R5: `pf_flush` discards every stored prefetch fault that has not yet been used, so a later use of that slot raises nothing.
- R6: A faulted released write (`acc_kind`=3) raises nothing until `insn_boundary` or `operand_attempt` is high in a later cycle; the request follows one cycle after that strobe.
- R7: `exc_req` is high for exactly one cycle per record. The record outputs stay unchanged until the core acknowledges with `req_ack` in a cycle where `exc_req` is low; an acknowledge during the pulse cycle is ignored.
- R8: A fault that arrives while a record awaits acknowledge goes to a one-entry holding register and is presented, with a new pulse, in the cycle after the acknowledge. An immediate fault that arrives while the holding register is full is dropped.
- R9: When sources compete in one cycle, an immediate data fault goes first, then a due released write, then a used prefetch (lowest slot first); the losers are delivered later in that order.
- R10: A bus error while `crit_phase` is high sets `halted` in the next cycle; `halted` then stays high, no `exc_req` is raised, and only reset clears it.
- R11: Reset clears `exc_req`, `halted`, all stored prefetch faults, the deferred write fault and the holding register within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_ext | input | 1 | Error from the external pin |
| err_mod | input | 1 | Error from an internal module |
| err_wdog | input | 1 | Error from the no-response watchdog |
| acc_valid | input | 1 | A bus cycle completes this clock |
| acc_kind | input | 2 | Access class: 0 prefetch, 1 read, 2 write, 3 released write |
| acc_size | input | 2 | Access size code |
| acc_fc | input | 3 | Function code of the access |
| acc_addr | input | ADDR_W | Address of the access |
| acc_slot | input | SLOT_W | Prefetch slot of a prefetch access |
| insn_boundary | input | 1 | Instruction boundary reached |
| operand_attempt | input | 1 | Core attempts an operand access |
| pf_use | input | 1 | Core consumes a prefetched word |
| pf_use_slot | input | SLOT_W | Slot of the consumed word |
| pf_flush | input | 1 | All prefetched words discarded |
| crit_phase | input | 1 | Core is in a phase where a bus error halts it |
| req_ack | input | 1 | Core has taken the presented record |
| exc_req | output | 1 | One-cycle bus-error exception request |
| rec_kind | output | 2 | Access class of the faulted cycle |
| rec_read | output | 1 | Faulted cycle was a read |
| rec_size | output | 2 | Size code of the faulted cycle |
| rec_fc | output | 3 | Function code of the faulted cycle |
| rec_addr | output | ADDR_W | Fault address |
| vector_num | output | 8 | Bus-error vector number |
| halted | output | 1 | Core halted by a double fault |

## Verification
The request and record outputs come from one register stage. They are due exactly one cycle after the triggering event: the fault for reads and writes, the use for prefetches, the boundary or operand strobe for released writes, and the acknowledge for a held record. `halted` is likewise due one cycle after the critical-phase fault. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands in that cycle. It also re-samples over several idle cycles to show that a dropped, flushed or not-yet-due fault produces no pulse. Arbitration order is checked by reading back the sequence of records that follows successive acknowledges.

// File: rtl/berr_pkg.sv
package berr_pkg;

    typedef enum logic [1:0] {
        ACC_PREFETCH = 2'd0,
        ACC_READ     = 2'd1,
        ACC_WRITE    = 2'd2,
        ACC_RELWR    = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic       is_read;
        logic [1:0] size;
        logic [2:0] fc;
    } fault_attr_t;

    localparam logic [7:0] BERR_VECTOR = 8'd2;

    function automatic logic kind_is_read(acc_kind_e k);
        return (k == ACC_PREFETCH) || (k == ACC_READ);
    endfunction

    function automatic logic kind_is_immediate(acc_kind_e k);
        return (k == ACC_READ) || (k == ACC_WRITE);
    endfunction

endpackage

// File: rtl/berr_pf_tracker.sv
module berr_pf_tracker
    import berr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PF_SLOTS = 4,
    localparam int SLOT_W  = (PF_SLOTS > 1) ? $clog2(PF_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [SLOT_W-1:0] cap_slot,
    input  fault_attr_t       cap_attr,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              use_en,
    input  logic [SLOT_W-1:0] use_slot,
    input  logic              flush,
    input  logic              take,
    output logic              avail,
    output fault_attr_t       out_attr,
    output logic [ADDR_W-1:0] out_addr
);

    logic [PF_SLOTS-1:0] pend_q, due_q, ready;
    fault_attr_t         attr_q [PF_SLOTS];
    logic [ADDR_W-1:0]   addr_q [PF_SLOTS];
    logic [SLOT_W-1:0]   sel;
    logic                use_now;

    assign use_now = use_en && !flush;

    // a slot is ready when consumed earlier (due) or consumed right now
    always_comb begin
        for (int i = 0; i < PF_SLOTS; i++) begin
            ready[i] = due_q[i] || (use_now && (use_slot == SLOT_W'(i)) && pend_q[i]);
        end
    end

    // lowest ready slot wins
    always_comb begin
        sel = '0;
        for (int i = PF_SLOTS - 1; i >= 0; i--) begin
            if (ready[i]) sel = SLOT_W'(i);
        end
    end

    assign avail    = |ready;
    assign out_attr = attr_q[sel];
    assign out_addr = addr_q[sel];

    for (genvar g = 0; g < PF_SLOTS; g++) begin : g_slot
        logic hit_use;
        assign hit_use = use_now && (use_slot == SLOT_W'(g)) && pend_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
                due_q[g]  <= 1'b0;
                attr_q[g] <= '0;
                addr_q[g] <= '0;
            end else begin
                if (flush || hit_use) pend_q[g] <= 1'b0;
                if (cap_en && (cap_slot == SLOT_W'(g))) begin
                    pend_q[g] <= 1'b1;
                    attr_q[g] <= cap_attr;
                    addr_q[g] <= cap_addr;
                end
                if (take && (sel == SLOT_W'(g))) due_q[g] <= 1'b0;
                else if (hit_use)                due_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/berr_wr_defer.sv
module berr_wr_defer
    import berr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  fault_attr_t       cap_attr,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              strobe,
    input  logic              take,
    output logic              avail,
    output fault_attr_t       out_attr,
    output logic [ADDR_W-1:0] out_addr
);

    logic pend_q, due_q;

    // released only by a strobe seen after capture
    assign avail = due_q || (pend_q && strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            due_q    <= 1'b0;
            out_attr <= '0;
            out_addr <= '0;
        end else begin
            if (take) begin
                pend_q <= 1'b0;
                due_q  <= 1'b0;
            end else if (pend_q && strobe) begin
                due_q <= 1'b1;
            end
            // an older deferred fault is kept over a newer one
            if (cap_en && (take || !pend_q)) begin
                pend_q   <= 1'b1;
                due_q    <= 1'b0;
                out_attr <= cap_attr;
                out_addr <= cap_addr;
            end
        end
    end

endmodule

// File: rtl/berr_deliver.sv
module berr_deliver
    import berr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  fault_attr_t       ev_attr,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ack,
    output logic              accept,
    output logic              busy,
    output logic              req,
    output fault_attr_t       rec_attr,
    output logic [ADDR_W-1:0] rec_addr
);

    logic              hold_v;
    fault_attr_t       hold_attr;
    logic [ADDR_W-1:0] hold_addr;
    logic              ack_ok;

    assign ack_ok = busy && ack && !req;
    assign accept = !busy || ack_ok || !hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            req       <= 1'b0;
            hold_v    <= 1'b0;
            rec_attr  <= '0;
            rec_addr  <= '0;
            hold_attr <= '0;
            hold_addr <= '0;
        end else begin
            req <= 1'b0;
            if (!busy) begin
                if (ev_valid) begin
                    rec_attr <= ev_attr;
                    rec_addr <= ev_addr;
                    busy     <= 1'b1;
                    req      <= 1'b1;
                end
            end else if (ack_ok) begin
                if (hold_v) begin
                    rec_attr <= hold_attr;
                    rec_addr <= hold_addr;
                    req      <= 1'b1;
                    hold_v   <= ev_valid;
                    if (ev_valid) begin
                        hold_attr <= ev_attr;
                        hold_addr <= ev_addr;
                    end
                end else if (ev_valid) begin
                    rec_attr <= ev_attr;
                    rec_addr <= ev_addr;
                    req      <= 1'b1;
                end else begin
                    busy <= 1'b0;
                end
            end else if (ev_valid && !hold_v) begin
                hold_attr <= ev_attr;
                hold_addr <= ev_addr;
                hold_v    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/berr_exc_ctrl.sv
module berr_exc_ctrl
    import berr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PF_SLOTS = 4,
    localparam int SLOT_W  = (PF_SLOTS > 1) ? $clog2(PF_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_ext,
    input  logic              err_mod,
    input  logic              err_wdog,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_size,
    input  logic [2:0]        acc_fc,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SLOT_W-1:0] acc_slot,
    input  logic              insn_boundary,
    input  logic              operand_attempt,
    input  logic              pf_use,
    input  logic [SLOT_W-1:0] pf_use_slot,
    input  logic              pf_flush,
    input  logic              crit_phase,
    input  logic              req_ack,
    output logic              exc_req,
    output logic [1:0]        rec_kind,
    output logic              rec_read,
    output logic [1:0]        rec_size,
    output logic [2:0]        rec_fc,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [7:0]        vector_num,
    output logic              halted
);

    fault_attr_t       acc_attr, pf_attr, wr_attr, ev_attr, rec_attr;
    logic [ADDR_W-1:0] pf_addr, wr_addr, ev_addr;
    logic              faulted, halt_now, live_fault;
    logic              imm_v, pf_cap, wr_cap, pf_av, wr_av;
    logic              pf_take, wr_take, ev_valid, accept, dl_busy;

    assign faulted    = acc_valid && (err_ext || err_mod || err_wdog);
    assign halt_now   = faulted && crit_phase && !halted;
    assign live_fault = faulted && !crit_phase && !halted;

    always_comb begin
        acc_attr.kind    = acc_kind_e'(acc_kind);
        acc_attr.is_read = kind_is_read(acc_kind_e'(acc_kind));
        acc_attr.size    = acc_size;
        acc_attr.fc      = acc_fc;
    end

    assign imm_v  = live_fault && kind_is_immediate(acc_attr.kind);
    assign pf_cap = live_fault && (acc_attr.kind == ACC_PREFETCH);
    assign wr_cap = live_fault && (acc_attr.kind == ACC_RELWR);

    berr_pf_tracker #(.ADDR_W(ADDR_W), .PF_SLOTS(PF_SLOTS)) pf_i (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (pf_cap),
        .cap_slot (acc_slot),
        .cap_attr (acc_attr),
        .cap_addr (acc_addr),
        .use_en   (pf_use),
        .use_slot (pf_use_slot),
        .flush    (pf_flush),
        .take     (pf_take),
        .avail    (pf_av),
        .out_attr (pf_attr),
        .out_addr (pf_addr)
    );

    berr_wr_defer #(.ADDR_W(ADDR_W)) wr_i (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (wr_cap),
        .cap_attr (acc_attr),
        .cap_addr (acc_addr),
        .strobe   (insn_boundary || operand_attempt),
        .take     (wr_take),
        .avail    (wr_av),
        .out_attr (wr_attr),
        .out_addr (wr_addr)
    );

    // fixed priority: immediate, then deferred write, then prefetch use
    logic gate;
    assign gate     = !halted && !halt_now;
    assign ev_valid = gate && (imm_v || wr_av || pf_av);
    assign wr_take  = gate && accept && !imm_v && wr_av;
    assign pf_take  = gate && accept && !imm_v && !wr_av && pf_av;

    always_comb begin
        if (imm_v) begin
            ev_attr = acc_attr;
            ev_addr = acc_addr;
        end else if (wr_av) begin
            ev_attr = wr_attr;
            ev_addr = wr_addr;
        end else begin
            ev_attr = pf_attr;
            ev_addr = pf_addr;
        end
    end

    berr_deliver #(.ADDR_W(ADDR_W)) dl_i (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_attr  (ev_attr),
        .ev_addr  (ev_addr),
        .ack      (req_ack && !halted),
        .accept   (accept),
        .busy     (dl_busy),
        .req      (exc_req),
        .rec_attr (rec_attr),
        .rec_addr (rec_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)           halted <= 1'b0;
        else if (halt_now) halted <= 1'b1;
    end

    assign rec_kind   = rec_attr.kind;
    assign rec_read   = rec_attr.is_read;
    assign rec_size   = rec_attr.size;
    assign rec_fc     = rec_attr.fc;
    assign vector_num = BERR_VECTOR;

endmodule

// File: rtl/berr_exc_ctrl_chk.sv
module berr_exc_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              err_ext,
    input logic              err_mod,
    input logic              err_wdog,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              crit_phase,
    input logic              req_ack,
    input logic              exc_req,
    input logic [2:0]        rec_fc,
    input logic [ADDR_W-1:0] rec_addr,
    input logic              halted,
    input logic              dl_busy
);

    logic any_err;
    assign any_err = err_ext || err_mod || err_wdog;

    // R7
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> !exc_req);

    // R7
    record_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dl_busy && !(req_ack && !exc_req)) |=> ($stable(rec_addr) && $stable(rec_fc)));

    // R2
    imm_req_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && any_err && !crit_phase && !halted && !dl_busy &&
         (acc_kind == 2'd1 || acc_kind == 2'd2))
        |=> (exc_req && rec_addr == $past(acc_addr)));

    // R10
    halt_on_crit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && any_err && crit_phase) |=> halted);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R10
    halt_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !exc_req);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!halted && !exc_req));

endmodule

bind berr_exc_ctrl berr_exc_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .err_ext    (err_ext),
    .err_mod    (err_mod),
    .err_wdog   (err_wdog),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .acc_addr   (acc_addr),
    .crit_phase (crit_phase),
    .req_ack    (req_ack),
    .exc_req    (exc_req),
    .rec_fc     (rec_fc),
    .rec_addr   (rec_addr),
    .halted     (halted),
    .dl_busy    (dl_busy)
);

// File: tb/berr_exc_ctrl_tb_top.sv
module berr_exc_ctrl_tb_top;

    localparam int AW = 32;
    localparam int SW = 2;

    localparam logic [1:0] K_PF = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_WR = 2'd2;
    localparam logic [1:0] K_RW = 2'd3;

    logic          clk = 1'b0;
    logic          rst;
    logic          err_ext, err_mod, err_wdog;
    logic          acc_valid;
    logic [1:0]    acc_kind, acc_size;
    logic [2:0]    acc_fc;
    logic [AW-1:0] acc_addr;
    logic [SW-1:0] acc_slot;
    logic          insn_boundary, operand_attempt;
    logic          pf_use, pf_flush, crit_phase, req_ack;
    logic [SW-1:0] pf_use_slot;
    logic          exc_req, rec_read, halted;
    logic [1:0]    rec_kind, rec_size;
    logic [2:0]    rec_fc;
    logic [AW-1:0] rec_addr;
    logic [7:0]    vector_num;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    berr_exc_ctrl #(.ADDR_W(AW), .PF_SLOTS(4)) dut_i (.*);

    function automatic logic exp_read(logic [1:0] k);
        return (k == K_PF) || (k == K_RD);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        {err_ext, err_mod, err_wdog} = 3'b000;
        acc_valid = 1'b0; acc_kind = 2'd0; acc_size = 2'd0; acc_fc = 3'd0;
        acc_addr = '0; acc_slot = '0;
        insn_boundary = 1'b0; operand_attempt = 1'b0;
        pf_use = 1'b0; pf_use_slot = '0; pf_flush = 1'b0; req_ack = 1'b0;
    endtask

    task automatic fault(logic [1:0] k, logic [1:0] sz, logic [2:0] fc,
                         logic [AW-1:0] a, logic [SW-1:0] slot, logic [2:0] mask);
        acc_valid = 1'b1; acc_kind = k; acc_size = sz; acc_fc = fc;
        acc_addr = a; acc_slot = slot;
        {err_wdog, err_mod, err_ext} = mask;
    endtask

    task automatic expect_rec(string req, logic [1:0] k, logic [1:0] sz,
                              logic [2:0] fc, logic [AW-1:0] a);
        check(req, "exc_req", 64'(exc_req), 64'd1);
        check(req, "rec_kind", 64'(rec_kind), 64'(k));
        check(req, "rec_read", 64'(rec_read), 64'(exp_read(k)));
        check(req, "rec_size", 64'(rec_size), 64'(sz));
        check(req, "rec_fc", 64'(rec_fc), 64'(fc));
        check(req, "rec_addr", 64'(rec_addr), 64'(a));
    endtask

    task automatic no_req(string req);
        check(req, "exc_req idle", 64'(exc_req), 64'd0);
    endtask

    task automatic do_ack();
        req_ack = 1'b1;
        tick();
        req_ack = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        clear_in();
        crit_phase = 1'b0;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R11 reset state, R3 vector
        check("R11", "exc_req", 64'(exc_req), 64'd0);
        check("R11", "halted", 64'(halted), 64'd0);
        check("R3", "vector_num", 64'(vector_num), 64'd2);

        // R1 each error source alone
        for (int s = 0; s < 3; s++) begin
            fault(K_RD, 2'd1, 3'd5, 32'h1000 + 32'(s), 2'd0, 3'(1 << s));
            tick(); clear_in();
            expect_rec("R1", K_RD, 2'd1, 3'd5, 32'h1000 + 32'(s));
            tick();
            no_req("R7");
            do_ack();
        end
        fault(K_RD, 2'd1, 3'd1, 32'h1100, 2'd0, 3'b000);
        tick(); clear_in();
        no_req("R1");

        // R2 / R3 ordinary write
        fault(K_WR, 2'd2, 3'd3, 32'h2000_0040, 2'd0, 3'b001);
        tick(); clear_in();
        expect_rec("R2", K_WR, 2'd2, 3'd3, 32'h2000_0040);
        tick(); do_ack();

        // R7 / R8 ack during pulse ignored, holding register, drop on full
        fault(K_RD, 2'd0, 3'd1, 32'hA1, 2'd0, 3'b010);
        tick(); clear_in();
        expect_rec("R7", K_RD, 2'd0, 3'd1, 32'hA1);
        req_ack = 1'b1; tick(); req_ack = 1'b0;
        no_req("R7");
        fault(K_WR, 2'd1, 3'd2, 32'hA2, 2'd0, 3'b100);
        tick(); clear_in();
        no_req("R8");
        check("R7", "rec_addr held", 64'(rec_addr), 64'hA1);
        fault(K_RD, 2'd3, 3'd7, 32'hA3, 2'd0, 3'b001);
        tick(); clear_in();
        no_req("R8");
        tick();
        check("R7", "rec_addr held", 64'(rec_addr), 64'hA1);
        do_ack();
        expect_rec("R8", K_WR, 2'd1, 3'd2, 32'hA2);
        tick(); do_ack();
        for (int i = 0; i < 3; i++) begin
            tick(); no_req("R8");
        end

        // R4 prefetch held until use
        fault(K_PF, 2'd1, 3'd6, 32'h4000, 2'd1, 3'b001);
        tick(); clear_in();
        no_req("R4");
        repeat (2) tick();
        no_req("R4");
        pf_use = 1'b1; pf_use_slot = 2'd1;
        tick(); clear_in();
        expect_rec("R4", K_PF, 2'd1, 3'd6, 32'h4000);
        tick(); do_ack();
        pf_use = 1'b1; pf_use_slot = 2'd1;
        tick(); clear_in();
        no_req("R4");

        // R5 flush drops pending prefetch fault
        fault(K_PF, 2'd1, 3'd6, 32'h5000, 2'd2, 3'b100);
        tick(); clear_in();
        pf_flush = 1'b1;
        tick(); clear_in();
        pf_use = 1'b1; pf_use_slot = 2'd2;
        tick(); clear_in();
        no_req("R5");
        tick();
        no_req("R5");

        // R6 released write waits for a later strobe
        fault(K_RW, 2'd2, 3'd1, 32'h6000, 2'd0, 3'b010);
        insn_boundary = 1'b1;
        tick(); clear_in();
        no_req("R6");
        repeat (2) tick();
        no_req("R6");
        insn_boundary = 1'b1;
        tick(); clear_in();
        expect_rec("R6", K_RW, 2'd2, 3'd1, 32'h6000);
        tick(); do_ack();
        fault(K_RW, 2'd0, 3'd5, 32'h7000, 2'd0, 3'b001);
        tick(); clear_in();
        no_req("R6");
        operand_attempt = 1'b1;
        tick(); clear_in();
        expect_rec("R6", K_RW, 2'd0, 3'd5, 32'h7000);
        tick(); do_ack();

        // R9 three sources in one cycle
        fault(K_PF, 2'd1, 3'd2, 32'h8000, 2'd0, 3'b001);
        tick(); clear_in();
        fault(K_RW, 2'd2, 3'd3, 32'h9000, 2'd0, 3'b001);
        tick(); clear_in();
        no_req("R9");
        fault(K_RD, 2'd3, 3'd4, 32'hA000, 2'd0, 3'b001);
        insn_boundary = 1'b1; pf_use = 1'b1; pf_use_slot = 2'd0;
        tick(); clear_in();
        expect_rec("R9", K_RD, 2'd3, 3'd4, 32'hA000);
        tick(); no_req("R9");
        do_ack();
        expect_rec("R9", K_RW, 2'd2, 3'd3, 32'h9000);
        tick(); do_ack();
        expect_rec("R9", K_PF, 2'd1, 3'd2, 32'h8000);
        tick(); do_ack();
        repeat (2) tick();
        no_req("R9");

        // R2 / R3 random immediate faults
        for (int i = 0; i < 40; i++) begin
            logic [1:0]    k  = ($urandom % 2) ? K_RD : K_WR;
            logic [2:0]    m  = 3'($urandom % 8);
            logic [1:0]    sz = 2'($urandom);
            logic [2:0]    fc = 3'($urandom);
            logic [AW-1:0] a  = AW'($urandom);
            fault(k, sz, fc, a, 2'd0, m);
            tick(); clear_in();
            if (m != 3'b000) begin
                expect_rec("R2", k, sz, fc, a);
                tick(); do_ack();
            end else begin
                no_req("R1");
            end
        end

        // R10 halt on fault in critical phase; leave a prefetch for R11
        fault(K_PF, 2'd1, 3'd1, 32'hB000, 2'd3, 3'b001);
        tick(); clear_in();
        crit_phase = 1'b1;
        fault(K_RD, 2'd1, 3'd1, 32'hC000, 2'd0, 3'b010);
        tick(); clear_in();
        crit_phase = 1'b0;
        check("R10", "halted", 64'(halted), 64'd1);
        no_req("R10");
        fault(K_RD, 2'd1, 3'd1, 32'hC004, 2'd0, 3'b001);
        tick(); clear_in();
        no_req("R10");
        pf_use = 1'b1; pf_use_slot = 2'd3;
        tick(); clear_in();
        no_req("R10");
        check("R10", "halted sticky", 64'(halted), 64'd1);

        // R11 reset clears halt and stored prefetch fault
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R11", "halted", 64'(halted), 64'd0);
        no_req("R11");
        pf_use = 1'b1; pf_use_slot = 2'd3;
        tick(); clear_in();
        no_req("R11");
        insn_boundary = 1'b1;
        tick(); clear_in();
        no_req("R11");

        summary();
        $finish;
    end

endmodule